// File: doc/BRIEF.md
# Register Busy-Bit Issue Gate

This block decides, cycle by cycle, whether one candidate instruction of the form `dst <- srcA op srcB` may leave the issue stage. It keeps one busy bit for every architectural register. A bit that is set means a result for that register is still in flight. Before it lets an instruction go, the block looks up the two source bits and the destination bit.

The instruction is dispatched in the same cycle only when all three registers are free. In that case the destination is reserved from the next clock edge on. If a source is busy, the instruction is held back for a read-after-write hazard. If the destination is busy, it is held back for a write-after-write hazard. Both reasons are reported on separate outputs.

A write-back port clears a busy bit whenever a result arrives, in any order relative to issue. The clear is also bypassed into the same cycle's hazard check. Register 0 is hard-wired free. A write-back to a register that was not reserved raises an error strobe and has no other effect.

Top module: `reg_busy_gate`

## Requirements
- R1: The block holds one busy bit per register, selected directly by the 4-bit register number (16 registers); 1 means reserved and 0 means free.
- R2: After reset every busy bit is 0, so any instruction presented first is dispatched.
- R3: With `iss_vld`=1 and `srcA`, `srcB` and `dst` all free, `iss_go`=1 in that same cycle, and `iss_stall`, `haz_raw` and `haz_waw` are 0.
- R4: If `iss_vld`=1 and `srcA` or `srcB` is busy, `haz_raw`=1, `iss_stall`=1 and `iss_go`=0.
- R5: If `iss_vld`=1 and `dst` is busy, `haz_waw`=1, `iss_stall`=1 and `iss_go`=0. `haz_raw` and `haz_waw` may both be 1.
- R6: With `iss_vld`=0, the outputs `iss_go`, `iss_stall`, `haz_raw` and `haz_waw` are all 0, and no bit changes because of issue.
- R7: A dispatch sets the busy bit of `dst` from the next clock edge. If a write-back to the same register arrives in the same cycle as that dispatch, the bit is left set.
- R8: A write-back (`wb_vld`=1) clears the bit of `wb_idx` at the next edge, for any register and in any order. In its own cycle it already counts as free for the hazard check.
- R9: A write-back to a register whose bit is 0 sets `wb_err`=1 in that cycle and leaves the bit unchanged.
- R10: Register 0 is never busy. A dispatch that writes register 0 reserves nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_vld | input | 1 | Candidate instruction present |
| iss_src_a | input | 4 | First source register number |
| iss_src_b | input | 4 | Second source register number |
| iss_dst | input | 4 | Destination register number |
| iss_go | output | 1 | Instruction dispatched this cycle |
| iss_stall | output | 1 | Instruction held this cycle |
| haz_raw | output | 1 | Hold caused by a busy source |
| haz_waw | output | 1 | Hold caused by a busy destination |
| wb_vld | input | 1 | Result arriving this cycle |
| wb_idx | input | 4 | Register receiving the result |
| wb_err | output | 1 | Result arrived for a register that was not reserved |

## Verification
The decision outputs and `wb_err` are combinational, so each one is due in the same cycle as the request it answers. Reservations and releases show up only from the following edge, through the hazard outcome of later requests. The driver applies each stimulus just after the falling edge and queues the outcome it expects, computed from a bench-side busy vector. The monitor takes that item out of the queue a few nanoseconds later, still before the rising edge. A check therefore always sees the state left by the previous edge together with the current request.

// File: rtl/rbg_pkg.sv
package rbg_pkg;
   typedef struct packed {
      logic raw;
      logic waw;
   } hazard_t;
endpackage

// File: rtl/rbg_idx_decode.sv
module rbg_idx_decode #(
   parameter int NREG = 16,
   parameter int IW   = $clog2(NREG)
) (
   input  logic            en,
   input  logic [IW-1:0]   idx,
   output logic [NREG-1:0] onehot
);
   for (genvar g = 0; g < NREG; g++) begin : g_bit
      assign onehot[g] = en && (idx == IW'(g));
   end
endmodule

// File: rtl/rbg_busy_store.sv
module rbg_busy_store #(
   parameter int NREG      = 16,
   parameter bit PIN_ZERO  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREG-1:0] clr_vec,
   input  logic [NREG-1:0] set_vec,
   output logic [NREG-1:0] busy_q
);
   for (genvar g = 0; g < NREG; g++) begin : g_cell
      logic bit_q;
      if (PIN_ZERO && g == 0) begin : g_pinned
         assign bit_q = 1'b0;
      end else begin : g_flop
         always_ff @(posedge clk) begin
            if (!rst_n)          bit_q <= 1'b0;
            else if (set_vec[g]) bit_q <= 1'b1;
            else if (clr_vec[g]) bit_q <= 1'b0;
         end
      end
      assign busy_q[g] = bit_q;
   end
endmodule

// File: rtl/rbg_hazard_eval.sv
module rbg_hazard_eval
   import rbg_pkg::*;
#(
   parameter int NREG = 16,
   parameter int IW   = $clog2(NREG)
) (
   input  logic            vld,
   input  logic [NREG-1:0] busy_eff,
   input  logic [IW-1:0]   src_a,
   input  logic [IW-1:0]   src_b,
   input  logic [IW-1:0]   dst,
   output hazard_t         haz,
   output logic            go
);
   always_comb begin
      haz.raw = vld && (busy_eff[src_a] || busy_eff[src_b]);
      haz.waw = vld && busy_eff[dst];
      go      = vld && !haz.raw && !haz.waw;
   end
endmodule

// File: rtl/reg_busy_gate.sv
module reg_busy_gate
   import rbg_pkg::*;
#(
   parameter int NREG     = 16,
   parameter bit PIN_ZERO = 1'b1,
   localparam int IW      = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          iss_vld,
   input  logic [IW-1:0] iss_src_a,
   input  logic [IW-1:0] iss_src_b,
   input  logic [IW-1:0] iss_dst,
   output logic          iss_go,
   output logic          iss_stall,
   output logic          haz_raw,
   output logic          haz_waw,
   input  logic          wb_vld,
   input  logic [IW-1:0] wb_idx,
   output logic          wb_err
);
   if (NREG < 2 || (1 << IW) != NREG) begin : g_bad_nreg
      $error("reg_busy_gate: NREG must be a power of two and at least 2");
   end

   logic [NREG-1:0] busy_q;
   logic [NREG-1:0] wb_oh;
   logic [NREG-1:0] rsv_oh;
   logic [NREG-1:0] busy_eff;
   hazard_t         haz;

   rbg_idx_decode #(.NREG(NREG), .IW(IW)) u_wb_dec (
      .en(wb_vld), .idx(wb_idx), .onehot(wb_oh));

   rbg_idx_decode #(.NREG(NREG), .IW(IW)) u_rsv_dec (
      .en(iss_go), .idx(iss_dst), .onehot(rsv_oh));

   assign busy_eff = busy_q & ~wb_oh;

   rbg_hazard_eval #(.NREG(NREG), .IW(IW)) u_eval (
      .vld(iss_vld), .busy_eff(busy_eff), .src_a(iss_src_a),
      .src_b(iss_src_b), .dst(iss_dst), .haz(haz), .go(iss_go));

   rbg_busy_store #(.NREG(NREG), .PIN_ZERO(PIN_ZERO)) u_store (
      .clk(clk), .rst_n(rst_n), .clr_vec(wb_oh), .set_vec(rsv_oh),
      .busy_q(busy_q));

   assign haz_raw   = haz.raw;
   assign haz_waw   = haz.waw;
   assign iss_stall = haz.raw || haz.waw;
   assign wb_err    = wb_vld && !busy_q[wb_idx];
endmodule

// File: rtl/rbg_chk.sv
module rbg_chk #(
   parameter int NREG = 16,
   parameter int IW   = $clog2(NREG)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            iss_vld,
   input logic [IW-1:0]   iss_dst,
   input logic            iss_go,
   input logic            iss_stall,
   input logic            wb_vld,
   input logic [IW-1:0]   wb_idx,
   input logic            wb_err,
   input logic [NREG-1:0] busy_q
);
   // R7
   reserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_go && iss_dst != '0) |=> busy_q[$past(iss_dst)]);
   // R8
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_vld && !(iss_go && iss_dst == wb_idx)) |=> !busy_q[$past(wb_idx)]);
   // R10
   zero_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q[0]);
   // R3
   go_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(iss_go && iss_stall));
   // R6
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_vld |-> (!iss_go && !iss_stall));
   // R9
   err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_err && !(iss_go && iss_dst == wb_idx)) |=> !busy_q[$past(wb_idx)]);
endmodule

bind reg_busy_gate rbg_chk #(.NREG(NREG), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_dst(iss_dst),
   .iss_go(iss_go), .iss_stall(iss_stall), .wb_vld(wb_vld),
   .wb_idx(wb_idx), .wb_err(wb_err), .busy_q(busy_q));

// File: tb/sim_reg_busy_gate.sv
module sim_reg_busy_gate;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic iss_vld = 1'b0, wb_vld = 1'b0;
   logic [3:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0, wb_idx = '0;
   logic iss_go, iss_stall, haz_raw, haz_waw, wb_err;

   always #10 clk = ~clk;

   reg_busy_gate u0 (
      .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_src_a(iss_src_a),
      .iss_src_b(iss_src_b), .iss_dst(iss_dst), .iss_go(iss_go),
      .iss_stall(iss_stall), .haz_raw(haz_raw), .haz_waw(haz_waw),
      .wb_vld(wb_vld), .wb_idx(wb_idx), .wb_err(wb_err));

   typedef struct {
      logic go, stall, raw, waw, err;
      string tag;
   } exp_t;

   exp_t q[$];
   int total = 0;
   int bad = 0;
   logic [15:0] mdl = '0;
   bit finished = 0;

   task automatic step(input logic v, input logic [3:0] a, input logic [3:0] b,
                       input logic [3:0] d, input logic w, input logic [3:0] wi,
                       input string tag);
      exp_t e;
      logic [15:0] eff;
      @(negedge clk);
      #1;
      iss_vld = v; iss_src_a = a; iss_src_b = b; iss_dst = d;
      wb_vld = w; wb_idx = wi;
      eff = mdl;
      if (w) eff[wi] = 1'b0;
      e.raw = v && (eff[a] || eff[b]);
      e.waw = v && eff[d];
      e.go = v && !e.raw && !e.waw;
      e.stall = e.raw || e.waw;
      e.err = w && !mdl[wi];
      e.tag = tag;
      q.push_back(e);
      mdl = eff;
      if (e.go && d != 4'd0) mdl[d] = 1'b1;
   endtask

   initial begin : monitor
      forever begin
         @(negedge clk);
         #5;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if ({iss_go, iss_stall, haz_raw, haz_waw, wb_err} !==
                {e.go, e.stall, e.raw, e.waw, e.err}) begin
               bad++;
               $display("FAIL %s: go/stall/raw/waw/err got %b%b%b%b%b exp %b%b%b%b%b",
                        e.tag, iss_go, iss_stall, haz_raw, haz_waw, wb_err,
                        e.go, e.stall, e.raw, e.waw, e.err);
            end
         end
      end
   end

   initial begin : watchdog
      #4000000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: run did not end, exp completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : driver
      logic [15:0] lf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R2 / R3: fresh state dispatches
      step(1, 4'd1, 4'd2, 4'd3, 0, 4'd0, "R2");
      // R5: destination 3 now reserved
      step(1, 4'd1, 4'd2, 4'd3, 0, 4'd0, "R5");
      // R4: source A and source B busy
      step(1, 4'd3, 4'd4, 4'd5, 0, 4'd0, "R4");
      step(1, 4'd4, 4'd3, 4'd5, 0, 4'd0, "R4");
      // R4 + R5 together
      step(1, 4'd3, 4'd3, 4'd3, 0, 4'd0, "R5");
      // R6: idle request
      step(0, 4'd3, 4'd3, 4'd3, 0, 4'd0, "R6");
      // R8: bypass of clear into same-cycle check
      step(1, 4'd3, 4'd1, 4'd5, 1, 4'd3, "R8");
      // R1: register 3 free, 5 busy
      step(1, 4'd3, 4'd3, 4'd6, 0, 4'd0, "R1");
      // R7: write-back and new reservation of 5 in one cycle
      step(1, 4'd1, 4'd2, 4'd5, 1, 4'd5, "R7");
      step(1, 4'd1, 4'd2, 4'd5, 0, 4'd0, "R7");
      // R9: write-back to free register 9
      step(0, 4'd0, 4'd0, 4'd0, 1, 4'd9, "R9");
      step(1, 4'd9, 4'd9, 4'd9, 0, 4'd0, "R9");
      // R10: register 0 never reserved
      step(1, 4'd1, 4'd2, 4'd0, 0, 4'd0, "R10");
      step(1, 4'd0, 4'd0, 4'd0, 0, 4'd0, "R10");
      // R8: release out of order
      step(0, 4'd0, 4'd0, 4'd0, 1, 4'd6, "R8");
      step(1, 4'd6, 4'd5, 4'd7, 0, 4'd0, "R8");
      // mixed traffic
      lf = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         step(lf[0] | lf[1], lf[5:2], lf[9:6], lf[13:10], lf[14], lf[3:0] ^ lf[15:12], "R1");
      end
      step(0, 4'd0, 4'd0, 4'd0, 0, 4'd0, "R6");
      repeat (3) @(negedge clk);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule